// File: doc/BRIEF.md
# Bit-Clock Recovery by Phase Accumulator

This block turns a fast system clock (100 MHz by default) into single-cycle strobes at a USB bit rate: 12 Mbps when full speed is selected and 1.5 Mbps when low speed is selected. A 32-bit phase accumulator grows by a rate-dependent step on every system cycle. Its most significant bit forms a square wave at the bit rate. The falling edge of that bit marks the receive sampling point, and the rising edge marks the transmit bit boundary. The ratio between the system clock and the bit rate is not an integer, so individual strobe spacings alternate between two neighbouring cycle counts. The long-run average stays on the nominal rate.

The receive data level first passes through a two-stage synchronizer. A change of level on the synchronized line is a bit boundary of the incoming NRZI stream. When one is seen, the accumulator is forced to half of full scale, so the next receive strobe falls half a bit cell later, near the centre of the cell. Both bit rates run through the same accumulator, and only the step changes. A receive deserializer takes the line level on each `sample_stb`. A transmit serializer moves to its next bit on each `tx_stb`.

Top module: `bitclk_recover`

## Requirements
- R1: While `rst_n` is low, both strobes are low and the accumulator is zero. After release at full speed, no strobe appears in the first four cycles, and `tx_stb` is high after the fifth rising edge.
- R2: With `low_speed` = 0, the step is 0x1EB851EC. With the data line steady, consecutive `sample_stb` pulses are 8 or 9 system cycles apart.
- R3: With `low_speed` = 1, the step is 0x03D70A3D. With the data line steady, consecutive `sample_stb` pulses are 66 or 67 system cycles apart.
- R4: Over a free-running stretch, the mean `sample_stb` spacing lies within one system cycle of 100 MHz divided by the selected bit rate.
- R5: `rxd` is taken through two synchronizer stages and a third stage for edge detection. A level change that is first captured at rising edge t forces the accumulator to 0x80000000 at rising edge t+2. The next `sample_stb` is then high after rising edge t+2+ceil(2^31/step): the 8th rising edge counted from t at full speed, and the 37th at low speed.
- R6: `sample_stb` is high for exactly one cycle when the accumulator MSB goes from 1 to 0. `tx_stb` is high for exactly one cycle when the MSB goes from 0 to 1. The two are never high together.
- R7: Every level change re-aligns the phase, including changes that arrive with a spacing that jitters by one cycle and runs without a change. The strobes keep following the most recent change.
- R8: In the cycle right after a re-alignment load, `sample_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| low_speed | input | 1 | 1 selects 1.5 Mbps, 0 selects 12 Mbps |
| rxd | input | 1 | Receive data line level (asynchronous) |
| sample_stb | output | 1 | One-cycle receive sampling strobe, mid-bit |
| tx_stb | output | 1 | One-cycle transmit bit-boundary strobe |

## Verification
An accumulator that holds a wrong phase shifts the next receive strobe at once. A wrong step value changes the spacing of strobes within a single bit period (about 9 cycles at full speed, 67 at low speed). A broken synchronizer depth or edge detector moves the strobe that follows an injected level change off the expected 8 or 37 cycles. A missed re-alignment under jittered NRZI traffic shows as strobes that disagree with the cycle-by-cycle model inside one bit cell. The mean spacing over thousands of cycles exposes a step that is slightly off, which single intervals would hide.

// File: rtl/bitclk_recover.sv
module bitclk_recover #(
  parameter int ACC_W = 32,
  parameter logic [ACC_W-1:0] STEP_FULL = 32'h1EB851EC,
  parameter logic [ACC_W-1:0] STEP_LOW  = 32'h03D70A3D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_speed,
  input  logic rxd,
  output logic sample_stb,
  output logic tx_stb
);
  localparam int MSB = ACC_W - 1;
  localparam logic [ACC_W-1:0] MID = {1'b1, {(ACC_W-1){1'b0}}};

  logic [2:0]       rx_pipe;
  logic [ACC_W-1:0] phase;
  logic             msb_q;

  wire              rx_edge = rx_pipe[1] ^ rx_pipe[2];
  wire [ACC_W-1:0]  step    = low_speed ? STEP_LOW : STEP_FULL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pipe <= '0;
      phase   <= '0;
      msb_q   <= 1'b0;
    end else begin
      rx_pipe <= {rx_pipe[1:0], rxd};
      phase   <= rx_edge ? MID : phase + step;
      msb_q   <= phase[MSB];
    end
  end

  assign sample_stb = msb_q & ~phase[MSB];
  assign tx_stb     = ~msb_q & phase[MSB];
endmodule

// File: rtl/bitclk_recover_chk.sv
module bitclk_recover_chk #(
  parameter int MAX_GAP = 70
) (
  input logic clk,
  input logic rst_n,
  input logic rxd,
  input logic sample_stb,
  input logic tx_stb
);
  logic [3:0] hist;
  logic       rx_last;
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    rx_last <= rxd;
    if (!rst_n) hist <= '0;
    else        hist <= {hist[2:0], rxd};
    if (!rst_n || sample_stb || (rxd != rx_last)) gap <= '0;
    else if (gap != 8'hFF)                        gap <= gap + 8'd1;
  end

  // R6
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb));

  // R6
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist[2] != hist[3]) |-> !sample_stb);

  // R3
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap) <= MAX_GAP);
endmodule

bind bitclk_recover bitclk_recover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rxd(rxd),
  .sample_stb(sample_stb), .tx_stb(tx_stb)
);

// File: tb/bitclk_recover_bench.sv
module bitclk_recover_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, low_speed = 1'b0, rxd = 1'b0;
  logic sample_stb, tx_stb;

  int unsigned n_tests = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  bit log_on = 0;
  int unsigned stamps[$];

  longint m_ph = 0;
  bit m_r1, m_r2, m_r3, m_pmsb, exp_s, exp_t;
  longint inc_fs, inc_ls;

  bitclk_recover u_bitclk_recover (
    .clk(clk), .rst_n(rst_n), .low_speed(low_speed), .rxd(rxd),
    .sample_stb(sample_stb), .tx_stb(tx_stb)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic longint step_of(real rate);
    return longint'($rtoi(rate * 4294967296.0 / 100.0e6 + 0.5));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: phase as an integer modulo 2^32
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_r1 = 0; m_r2 = 0; m_r3 = 0; m_pmsb = 0;
    end else begin
      m_pmsb = (m_ph >= 64'd2147483648);
      if (m_r2 != m_r3) m_ph = 64'd2147483648;
      else              m_ph = (m_ph + (low_speed ? inc_ls : inc_fs)) % 64'd4294967296;
      m_r3 = m_r2; m_r2 = m_r1; m_r1 = rxd;
    end
    exp_s = m_pmsb && (m_ph < 64'd2147483648);
    exp_t = !m_pmsb && (m_ph >= 64'd2147483648);
  end

  always @(negedge clk) begin
    check(sample_stb === exp_s, {tag, " sample_stb vs model"}, sample_stb, exp_s);
    check(tx_stb === exp_t, {tag, " tx_stb vs model"}, tx_stb, exp_t);
    if (log_on && sample_stb) stamps.push_back(cyc);
  end

  task automatic measure(int unsigned cycles, int lo, int hi, string req, real nominal);
    real mean;
    stamps.delete();
    log_on = 1;
    repeat (cycles) @(negedge clk);
    log_on = 0;
    check(stamps.size() > 2, req, stamps.size(), 3);
    for (int i = 1; i < stamps.size(); i++) begin
      int d = int'(stamps[i] - stamps[i-1]);
      check(d >= lo && d <= hi, {req, " interval"}, d, lo);
    end
    if (stamps.size() > 2) begin
      mean = real'(stamps[stamps.size()-1] - stamps[0]) / real'(stamps.size() - 1);
      check(mean > nominal - 1.0 && mean < nominal + 1.0, "R4 mean spacing x100",
            longint'($rtoi(mean * 100.0)), longint'($rtoi(nominal * 100.0)));
    end
  endtask

  task automatic edge_latency(int expect_n, string req);
    int n = 0, got = -1;
    rxd = ~rxd;
    repeat (expect_n + 5) begin
      @(negedge clk);
      n++;
      if (n == 3) check(!sample_stb, "R8 no strobe right after load", sample_stb, 0);
      if (n >= 3 && got < 0 && sample_stb) got = n;
    end
    check(got == expect_n, req, got, expect_n);
  endtask

  task automatic nrzi_run(int bits, int lo, int hi);
    int same = 0;
    for (int b = 0; b < bits; b++) begin
      if ($urandom_range(1, 0) == 1 || same >= 5) begin
        rxd = ~rxd; same = 0;
      end else same++;
      repeat ($urandom_range(hi, lo)) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    inc_fs = step_of(12.0e6);
    inc_ls = step_of(1.5e6);
    check(inc_fs == 64'h1EB851EC, "R2 step", inc_fs, 64'h1EB851EC);
    check(inc_ls == 64'h03D70A3D, "R3 step", inc_ls, 64'h03D70A3D);

    tag = "R1";
    repeat (5) @(negedge clk);
    check(sample_stb == 0, "R1 sample_stb in reset", sample_stb, 0);
    check(tx_stb == 0, "R1 tx_stb in reset", tx_stb, 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(!sample_stb && !tx_stb, "R1 quiet after release", sample_stb | tx_stb, 0);
    end
    @(negedge clk);
    check(tx_stb == 1, "R1 first tx_stb", tx_stb, 1);

    tag = "R2";
    measure(400, 8, 9, "R2 full-speed spacing", 100.0 / 12.0);

    tag = "R3";
    low_speed = 1'b1;
    repeat (70) @(negedge clk);
    measure(3000, 66, 67, "R3 low-speed spacing", 100.0 / 1.5);

    tag = "R5";
    edge_latency(37, "R5 low-speed edge to strobe");
    repeat (20) @(negedge clk);
    edge_latency(37, "R5 low-speed edge to strobe");
    low_speed = 1'b0;
    repeat (13) @(negedge clk);
    edge_latency(8, "R5 full-speed edge to strobe");
    repeat (3) @(negedge clk);
    edge_latency(8, "R5 full-speed edge to strobe");

    tag = "R7";
    nrzi_run(300, 8, 9);
    low_speed = 1'b1;
    nrzi_run(40, 66, 67);
    low_speed = 1'b0;
    nrzi_run(100, 8, 9);

    tag = "R6";
    repeat (100) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule